// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block gathers twenty-four maskable interrupt request lines and offers the single most urgent one to the processor as a 16-bit vector address. Each line has a pending flag that is set on the line's rising edge. A flag takes part in selection only while its own enable bit and the global enable are both 1. The lowest source index always wins.

The processor raises a strobe in the last cycle of each instruction. On the first cycle of that strobe, the block accepts the source it is showing, clears that source's flag and gives a one-cycle acknowledge. Software reaches the enable bits, the global enable and the flags through a small write port. The enable bits and the flags are each split into groups of six.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, all enables, the global enable and all flags are 0, and `irq_valid`, `irq_vector` and `irq_ack` are 0.
- R2: A flag is set only by a low-to-high transition of its request line. A request that stays high after its flag has been accepted does not set the flag again.
- R3: A flag sets while its source is disabled. Once the source is enabled, `irq_valid` rises one clock edge after the enabling write takes effect.
- R4: The global enable is bit 7 of a write with `wr_sel`=0. While it is 0, `irq_valid` is 0 and no acceptance happens, and the pending flags are kept.
- R5: A write with `wr_sel`=g (g=0..3) loads bit k of `wr_data[5:0]` into the enable of source 6g+k.
- R6: When several sources are eligible, the one with the lowest index is presented.
- R7: The vector for source n is 3 + 8n (0x0003 for source 0 up to 0x00BB for source 23).
- R8: Acceptance happens on the first clock edge at which `eoi` is high while `irq_valid` is 1. At that edge the presented flag clears, and `irq_ack` is high for exactly the following cycle.
- R9: `irq_valid` and `irq_vector` do not change at an edge where `eoi` is high. They follow the flags again one edge after `eoi` falls.
- R10: A write with `wr_sel`=4+g loads `wr_data[5:0]` into the flags of sources 6g..6g+5. This can both raise and drop pending requests.
- R11: A rising request edge in the same cycle as that source's acceptance leaves its flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 24 | Request lines, bit n is source n |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target: 0..3 enable groups, 4..7 flag groups |
| wr_data | input | 8 | Write data; bits 5:0 group bits, bit 7 global enable (select 0) |
| eoi | input | 1 | Last cycle of the current instruction |
| irq_valid | output | 1 | A source is offered |
| irq_vector | output | 16 | Vector address of the offered source |
| irq_ack | output | 1 | One-cycle pulse after acceptance |

## Verification
A request edge reaches the flag at the first clock edge. It reaches `irq_valid`/`irq_vector` at the second edge, and an enable or flag write shows at the output one edge after the write edge. The bench drives inputs on falling edges and waits exactly that many falling edges before it samples. A driver task queues the expected vector for each `eoi` strobe. A monitor checks the presented vector just after the strobe is driven and checks `irq_ack` one cycle later. In the hold cases, the bench samples again on every cycle while `eoi` stays high.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
   // Vector address of source idx in a base-plus-stride table
   function automatic int unsigned irqv_vec_addr(int unsigned base, int unsigned stride,
                                                 int unsigned idx);
      return base + stride * idx;
   endfunction
endpackage

// File: rtl/irqv_regs.sv
module irqv_regs #(
   parameter int NUM_SRC = 24,
   parameter int GROUP_W = 6,
   parameter int DATA_W  = 8,
   parameter int SEL_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [SEL_W-1:0]   wr_sel,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [NUM_SRC-1:0] en,
   output logic               ea,
   output logic [NUM_SRC-1:0] flag_wr_mask,
   output logic [NUM_SRC-1:0] flag_wr_val
);
   localparam int GROUPS = NUM_SRC / GROUP_W;
   localparam int GRP_W  = SEL_W - 1;

   logic [GRP_W-1:0] grp;
   logic             to_flags;

   assign grp      = wr_sel[GRP_W-1:0];
   assign to_flags = wr_sel[SEL_W-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en <= '0;
         ea <= 1'b0;
      end else if (wr_en && !to_flags && (int'(grp) < GROUPS)) begin
         en[int'(grp)*GROUP_W +: GROUP_W] <= wr_data[GROUP_W-1:0];
         if (grp == '0) ea <= wr_data[DATA_W-1];
      end
   end

   for (genvar g = 0; g < GROUPS; g++) begin : g_flag_wr
      assign flag_wr_mask[g*GROUP_W +: GROUP_W] =
         {GROUP_W{wr_en && to_flags && (grp == GRP_W'(g))}};
      assign flag_wr_val[g*GROUP_W +: GROUP_W] = wr_data[GROUP_W-1:0];
   end

   // R5: an enable-group write lands in exactly the addressed group
   a_r5_group_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !to_flags && grp == '0) |=> (en[GROUP_W-1:0] == $past(wr_data[GROUP_W-1:0])));
endmodule

// File: rtl/irqv_pending.sv
module irqv_pending #(
   parameter int NUM_SRC = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req,
   input  logic [NUM_SRC-1:0] clr,
   input  logic [NUM_SRC-1:0] wr_mask,
   input  logic [NUM_SRC-1:0] wr_val,
   output logic [NUM_SRC-1:0] flags
);
   logic [NUM_SRC-1:0] req_q;
   logic [NUM_SRC-1:0] set;

   always_ff @(posedge clk) begin
      if (!rst_n) req_q <= '0;
      else        req_q <= req;
   end

   assign set = req & ~req_q;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n)          flags[i] <= 1'b0;
         else if (set[i])     flags[i] <= 1'b1;
         else if (wr_mask[i]) flags[i] <= wr_val[i];
         else if (clr[i])     flags[i] <= 1'b0;
      end
   end

   // R11: a rising edge always leaves its flag set
   a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flags & $past(set)) == $past(set)));
   // R8: an acknowledge clear without a competing set or write drops the flag
   a_r8_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flags & $past(clr & ~set & ~wr_mask)) == '0));
   // R2: a held-high request line never sets a flag
   a_r2_no_level_set: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flags & ~$past(flags) & ~$past(set) & ~$past(wr_mask)) == '0));
endmodule

// File: rtl/irqv_select.sv
module irqv_select #(
   parameter int NUM_SRC = 24,
   parameter int IDX_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] elig,
   output logic               hit,
   output logic [IDX_W-1:0]   idx
);
   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (elig[i]) begin
            hit = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end

   // R6: the winner is eligible and nothing of lower index is
   a_r6_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (elig[idx] && ((elig & ((NUM_SRC'(1) << idx) - NUM_SRC'(1))) == '0)));
   a_r6_hit_iff_any: assert property (@(posedge clk) disable iff (!rst_n)
      hit == (|elig));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
   parameter int NUM_SRC    = 24,
   parameter int GROUP_W    = 6,
   parameter int DATA_W     = 8,
   parameter int VEC_W      = 16,
   parameter int VEC_BASE   = 3,
   parameter int VEC_STRIDE = 8,
   localparam int GROUPS    = NUM_SRC / GROUP_W,
   localparam int SEL_W     = $clog2(GROUPS) + 1,
   localparam int IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_req,
   input  logic               wr_en,
   input  logic [SEL_W-1:0]   wr_sel,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               eoi,
   output logic               irq_valid,
   output logic [VEC_W-1:0]   irq_vector,
   output logic               irq_ack
);
   import irqv_pkg::*;

   localparam int LAST_VEC = VEC_BASE + VEC_STRIDE * (NUM_SRC - 1);

   if (GROUPS * GROUP_W != NUM_SRC) begin : g_bad_groups
      $error("NUM_SRC must be a multiple of GROUP_W");
   end
   if (GROUPS < 2) begin : g_bad_count
      $error("at least two groups are needed");
   end
   if (GROUP_W >= DATA_W) begin : g_bad_data
      $error("DATA_W must leave its top bit for the global enable");
   end
   if (LAST_VEC >= (1 << VEC_W)) begin : g_bad_vec
      $error("vector table does not fit in VEC_W bits");
   end

   logic [NUM_SRC-1:0] en, flags, flag_wr_mask, flag_wr_val, elig, clr;
   logic               ea, hit, eoi_q, accept;
   logic [IDX_W-1:0]   idx, idx_q;

   irqv_regs #(.NUM_SRC(NUM_SRC), .GROUP_W(GROUP_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .en(en), .ea(ea), .flag_wr_mask(flag_wr_mask), .flag_wr_val(flag_wr_val)
   );

   irqv_pending #(.NUM_SRC(NUM_SRC)) u_pending (
      .clk(clk), .rst_n(rst_n), .req(irq_req), .clr(clr),
      .wr_mask(flag_wr_mask), .wr_val(flag_wr_val), .flags(flags)
   );

   assign elig = flags & en & {NUM_SRC{ea}};

   irqv_select #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_select (
      .clk(clk), .rst_n(rst_n), .elig(elig), .hit(hit), .idx(idx)
   );

   assign accept = eoi && !eoi_q && irq_valid;
   assign clr    = accept ? (NUM_SRC'(1) << idx_q) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         eoi_q      <= 1'b0;
         irq_valid  <= 1'b0;
         irq_vector <= '0;
         idx_q      <= '0;
         irq_ack    <= 1'b0;
      end else begin
         eoi_q   <= eoi;
         irq_ack <= accept;
         if (!eoi) begin
            irq_valid  <= hit;
            idx_q      <= idx;
            irq_vector <= hit ? VEC_W'(irqv_vec_addr(VEC_BASE, VEC_STRIDE, int'(idx))) : '0;
         end
      end
   end

   // R9: outputs frozen across an edge with eoi high
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      eoi |=> ($stable(irq_vector) && $stable(irq_valid)));
   // R8: acknowledge is a single-cycle pulse
   a_r8_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> !irq_ack);
   // R7: an offered vector lies on the base-plus-stride grid
   a_r7_vector_grid: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> (int'(irq_vector) >= VEC_BASE && int'(irq_vector) <= LAST_VEC &&
                     ((int'(irq_vector) - VEC_BASE) % VEC_STRIDE) == 0));
   // R4: nothing new is offered while the global enable is off
   a_r4_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (!ea && !eoi) |=> !irq_valid);
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] irq_req = '0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = '0;
   logic [7:0]  wr_data = '0;
   logic        eoi = 1'b0;
   logic        irq_valid, irq_ack;
   logic [15:0] irq_vector;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [16:0] exp_q[$];

   always #5 clk = ~clk;

   irq_vector_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .eoi(eoi), .irq_valid(irq_valid), .irq_vector(irq_vector),
      .irq_ack(irq_ack)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [2:0] sel, logic [7:0] data);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      step(1);
      wr_en = 1'b0;
   endtask

   // driver: queue the expected offer, strobe eoi for one cycle, wait for refresh
   task automatic accept(logic v, logic [15:0] vec);
      exp_q.push_back({v, vec});
      eoi = 1'b1;
      step(1);
      eoi = 1'b0;
      step(1);
   endtask

   // monitor: compare the offer at each new eoi, then the acknowledge a cycle later
   initial begin
      logic eoi_prev = 1'b0;
      logic ack_due = 1'b0;
      logic ack_pending = 1'b0;
      forever begin
         @(negedge clk);
         #1;
         if (ack_pending) begin
            check("R8 ack pulse", {31'd0, irq_ack}, {31'd0, ack_due});
            ack_pending = 1'b0;
         end
         if (eoi && !eoi_prev && exp_q.size() > 0) begin
            logic [16:0] e;
            e = exp_q.pop_front();
            check("R8 offered valid", {31'd0, irq_valid}, {31'd0, e[16]});
            check("R7 offered vector", {16'd0, irq_vector}, {16'd0, e[15:0]});
            ack_due = e[16];
            ack_pending = 1'b1;
         end
         eoi_prev = eoi;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1 reset state
      check("R1 valid", {31'd0, irq_valid}, 0);
      check("R1 vector", {16'd0, irq_vector}, 0);
      check("R1 ack", {31'd0, irq_ack}, 0);
      accept(1'b0, 16'h0000);

      // R3 flag sets while disabled; R5 group 0 bit 5 -> source 5
      wr(3'd0, 8'h80);
      irq_req[5] = 1'b1;
      step(2);
      check("R3 disabled no offer", {31'd0, irq_valid}, 0);
      wr(3'd0, 8'hA0);
      step(1);
      check("R3 offered once enabled", {31'd0, irq_valid}, 1);
      check("R5 R7 vector src5", {16'd0, irq_vector}, 32'h2B);
      accept(1'b1, 16'h002B);
      check("R2 held request not re-set", {31'd0, irq_valid}, 0);
      irq_req[5] = 1'b0;

      // R6 priority across groups
      wr(3'd0, 8'hBF); wr(3'd1, 8'h3F); wr(3'd2, 8'h3F); wr(3'd3, 8'h3F);
      irq_req[20] = 1'b1; irq_req[7] = 1'b1; irq_req[12] = 1'b1;
      step(2);
      check("R6 lowest index first", {16'd0, irq_vector}, 32'h3B);
      accept(1'b1, 16'h003B);
      accept(1'b1, 16'h0063);
      accept(1'b1, 16'h00A3);
      check("R8 all served", {31'd0, irq_valid}, 0);
      irq_req = '0;

      // R4 global enable gate keeps flags
      irq_req[0] = 1'b1;
      step(1);
      irq_req[0] = 1'b0;
      step(1);
      check("R7 vector src0", {16'd0, irq_vector}, 32'h03);
      wr(3'd0, 8'h3F);
      step(1);
      check("R4 EA off no offer", {31'd0, irq_valid}, 0);
      accept(1'b0, 16'h0000);
      wr(3'd0, 8'hBF);
      step(1);
      check("R4 flag kept", {16'd0, irq_vector}, 32'h03);
      accept(1'b1, 16'h0003);

      // R10 software flag writes
      wr(3'd7, 8'h20);
      step(1);
      check("R10 sw set src23", {16'd0, irq_vector}, 32'hBB);
      wr(3'd7, 8'h00);
      step(1);
      check("R10 sw clear", {31'd0, irq_valid}, 0);
      wr(3'd5, 8'h01);
      step(1);
      accept(1'b1, 16'h0033);

      // R9 hold while eoi stays high
      wr(3'd5, 8'h10);
      step(1);
      exp_q.push_back({1'b1, 16'h0053});
      eoi = 1'b1;
      irq_req[1] = 1'b1;
      step(1);
      check("R9 hold vector c1", {16'd0, irq_vector}, 32'h53);
      check("R9 hold valid c1", {31'd0, irq_valid}, 1);
      step(1);
      check("R9 hold vector c2", {16'd0, irq_vector}, 32'h53);
      check("R8 single ack", {31'd0, irq_ack}, 0);
      eoi = 1'b0;
      step(1);
      check("R9 refresh after eoi", {16'd0, irq_vector}, 32'h0B);
      accept(1'b1, 16'h000B);
      irq_req[1] = 1'b0;

      // R11 set wins over acceptance clear
      wr(3'd4, 8'h04);
      step(1);
      check("R10 sw set src2", {16'd0, irq_vector}, 32'h13);
      exp_q.push_back({1'b1, 16'h0013});
      eoi = 1'b1;
      irq_req[2] = 1'b1;
      step(1);
      eoi = 1'b0;
      step(1);
      check("R11 flag survives", {16'd0, irq_vector}, 32'h13);
      accept(1'b1, 16'h0013);
      check("R2 no re-set", {31'd0, irq_valid}, 0);
      irq_req = '0;
      step(3);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule